// File: doc/BRIEF.md
# Channel Fault Register and Fault Flag

This block holds the per-channel fault state of an eight-channel low-side output stage. For each channel it keeps two sticky flags. One records an overcurrent event and the other records an open-load event. Together they form a 16-bit fault word. The block also drives one active-low fault line that several devices can share. The analog comparators are outside the block. They reach it as per-channel detect strobes that are sampled on the clock.

An overcurrent flag forces its channel off until the flag is cleared. Each flag clears in one of two ways: a global fault-reset pulse, or a change of the channel's data bit in the direction that removes the condition. Writing the bit to 0 clears an overcurrent flag, and writing it to 1 clears an open-load flag. An over-temperature input disables all outputs and pulls the fault line low without storing anything. An undervoltage input wipes all state and disables the outputs without asserting the fault line. A build-time parameter can remove open-load detection.

Top module: `chan_fault_reg`

## Requirements
- R1: While rst_ni is low, fault_word_o is 0, force_off_o is 0, fault_no is 1 and out_dis_o is 0. This holds asynchronously, without waiting for a clock edge.
- R2: Channel i's overcurrent flag sits at fault_word_o bit 8+i and its open-load flag at bit i (0-based). Channel 7 is the highest in each half.
- R3: If oc_det_i[i] is high at a clock edge, the overcurrent flag of channel i is set after that edge. force_off_o[i] is high exactly while that flag is set.
- R4: An overcurrent flag clears at the first edge where data_i[i] is sampled 0 after being sampled 1. A detect at the same edge keeps the flag set.
- R5: ol_det_i[i] sets the open-load flag only when data_i[i] is 0 at the same edge. While data_i[i] is 1 the detect is ignored.
- R6: An open-load flag clears at the first edge where data_i[i] is sampled 1 after being sampled 0.
- R7: flt_clr_i high at an edge clears all 16 flags, and it overrides detects at that same edge.
- R8: When uv_i is low, fault_no is low whenever any flag is set or ot_i is high, and it is high otherwise.
- R9: ot_i high drives out_dis_o high and fault_no low in the same cycle, and leaves the flags unchanged. Both outputs return to their previous state when ot_i falls.
- R10: While uv_i is high, out_dis_o is 1 and fault_no is 1, detects are ignored, and all flags are 0 from the next edge on.
- R11: With OL_DET_EN = 0, fault_word_o bits 7..0 are always 0. The overcurrent half behaves the same as with OL_DET_EN = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oc_det_i | input | NUM_CH | Per-channel overcurrent detect strobe |
| ol_det_i | input | NUM_CH | Per-channel open-load detect strobe |
| data_i | input | NUM_CH | Per-channel on/off data bit, 1 = on |
| ot_i | input | 1 | Over-temperature condition |
| uv_i | input | 1 | Undervoltage condition |
| flt_clr_i | input | 1 | Fault-reset pulse |
| fault_word_o | output | 2*NUM_CH | Flags: overcurrent in the upper half, open-load in the lower half |
| force_off_o | output | NUM_CH | Per-channel forced-off mask |
| out_dis_o | output | 1 | Global output disable |
| fault_no | output | 1 | Shared fault line, active low |

## Verification
A stuck or wrongly cleared flag appears in fault_word_o one edge after the stimulus that should have changed it. The same error shows on fault_no and force_off_o in that cycle. An edge detector that held the wrong previous data value would clear a flag one edge early or late, or would not clear it at all. The bench applies each data transition and then samples right after the next edge. The combinational paths from ot_i and uv_i are checked within the cycle the input changes, and so is the priority of clear over set.

// File: rtl/chan_fault_pkg.sv
package chan_fault_pkg;
  localparam int unsigned NUM_CH_DEF = 8;

  typedef struct packed {
    logic oc;
    logic ol;
  } flag_pair_t;
endpackage

// File: rtl/fault_ch_cell.sv
module fault_ch_cell
  import chan_fault_pkg::*;
#(
  parameter bit OL_DET_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uv_i,
  input  logic       clr_i,
  input  logic       oc_det_i,
  input  logic       ol_det_i,
  input  logic       data_i,
  output flag_pair_t flags_o
);
  logic data_q;
  logic oc_q;
  logic data_fall, data_rise, wipe;

  assign wipe      = uv_i | clr_i;
  assign data_fall = data_q & ~data_i;
  assign data_rise = ~data_q & data_i;

  // previous data sample; undervoltage wipes it with everything else
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= 1'b0;
    else if (uv_i) data_q <= 1'b0;
    else           data_q <= data_i;
  end

  // new detect wins over the auto-clear edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   oc_q <= 1'b0;
    else if (wipe) oc_q <= 1'b0;
    else           oc_q <= oc_det_i | (oc_q & ~data_fall);
  end

  generate
    if (OL_DET_EN) begin : g_ol
      logic ol_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   ol_q <= 1'b0;
        else if (wipe) ol_q <= 1'b0;
        else           ol_q <= (ol_det_i & ~data_i) | (ol_q & ~data_rise);
      end
      assign flags_o.ol = ol_q;
    end else begin : g_no_ol
      logic unused_ol;
      assign unused_ol  = ol_det_i;
      assign flags_o.ol = 1'b0;
    end
  endgenerate

  assign flags_o.oc = oc_q;
endmodule

// File: rtl/fault_flag_merge.sv
module fault_flag_merge
  import chan_fault_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  localparam int unsigned WORD_W = 2 * NUM_CH
) (
  input  flag_pair_t [NUM_CH-1:0] flags_i,
  input  logic                    ot_i,
  input  logic                    uv_i,
  output logic [WORD_W-1:0]       fault_word_o,
  output logic [NUM_CH-1:0]       force_off_o,
  output logic                    out_dis_o,
  output logic                    fault_no
);
  logic any_flag;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      fault_word_o[NUM_CH+i] = flags_i[i].oc;
      fault_word_o[i]        = flags_i[i].ol;
      force_off_o[i]         = flags_i[i].oc;
    end
  end

  assign any_flag  = |fault_word_o;
  assign out_dis_o = ot_i | uv_i;
  // undervoltage is silent on the shared line
  assign fault_no  = uv_i | ~(any_flag | ot_i);
endmodule

// File: rtl/chan_fault_reg.sv
module chan_fault_reg
  import chan_fault_pkg::*;
#(
  parameter int unsigned NUM_CH    = NUM_CH_DEF,
  parameter bit          OL_DET_EN = 1'b1,
  localparam int unsigned WORD_W   = 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] oc_det_i,
  input  logic [NUM_CH-1:0] ol_det_i,
  input  logic [NUM_CH-1:0] data_i,
  input  logic              ot_i,
  input  logic              uv_i,
  input  logic              flt_clr_i,
  output logic [WORD_W-1:0] fault_word_o,
  output logic [NUM_CH-1:0] force_off_o,
  output logic              out_dis_o,
  output logic              fault_no
);
  flag_pair_t [NUM_CH-1:0] flags;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      fault_ch_cell #(.OL_DET_EN(OL_DET_EN)) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .uv_i    (uv_i),
        .clr_i   (flt_clr_i),
        .oc_det_i(oc_det_i[g]),
        .ol_det_i(ol_det_i[g]),
        .data_i  (data_i[g]),
        .flags_o (flags[g])
      );
    end
  endgenerate

  fault_flag_merge #(.NUM_CH(NUM_CH)) u_merge (
    .flags_i     (flags),
    .ot_i        (ot_i),
    .uv_i        (uv_i),
    .fault_word_o(fault_word_o),
    .force_off_o (force_off_o),
    .out_dis_o   (out_dis_o),
    .fault_no    (fault_no)
  );
endmodule

// File: rtl/chan_fault_reg_chk.sv
module chan_fault_reg_chk #(
  parameter int unsigned NUM_CH    = 8,
  parameter bit          OL_DET_EN = 1'b1,
  localparam int unsigned WORD_W   = 2 * NUM_CH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] oc_det_i,
  input logic [NUM_CH-1:0] ol_det_i,
  input logic [NUM_CH-1:0] data_i,
  input logic              ot_i,
  input logic              uv_i,
  input logic              flt_clr_i,
  input logic [WORD_W-1:0] fault_word_o,
  input logic [NUM_CH-1:0] force_off_o,
  input logic              out_dis_o,
  input logic              fault_no
);
  a_r3_oc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && !flt_clr_i) |=>
      ((fault_word_o[WORD_W-1:NUM_CH] & $past(oc_det_i)) == $past(oc_det_i)));

  a_r3_mask_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_o == fault_word_o[WORD_W-1:NUM_CH]);

  a_r5_ol_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fault_word_o[NUM_CH-1:0] & ~$past(fault_word_o[NUM_CH-1:0])
               & $past(data_i)) == '0));

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_clr_i || uv_i) |=> (fault_word_o == '0));

  a_r8_flag_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|fault_word_o) && !uv_i) |-> !fault_no);

  a_r9_ot_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> out_dis_o);

  a_r10_uv_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> (fault_no && out_dis_o));

  a_r11_no_ol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !OL_DET_EN |-> (fault_word_o[NUM_CH-1:0] == '0));
endmodule

bind chan_fault_reg chan_fault_reg_chk #(
  .NUM_CH   (NUM_CH),
  .OL_DET_EN(OL_DET_EN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .oc_det_i    (oc_det_i),
  .ol_det_i    (ol_det_i),
  .data_i      (data_i),
  .ot_i        (ot_i),
  .uv_i        (uv_i),
  .flt_clr_i   (flt_clr_i),
  .fault_word_o(fault_word_o),
  .force_off_o (force_off_o),
  .out_dis_o   (out_dis_o),
  .fault_no    (fault_no)
);

// File: tb/tb_chan_fault_reg.sv
module tb_chan_fault_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] oc_det_i = '0, ol_det_i = '0, data_i = '0;
  logic       ot_i = 1'b0, uv_i = 1'b0, flt_clr_i = 1'b0;
  logic [15:0] word, word_nol;
  logic [7:0]  foff, foff_nol;
  logic        dis, dis_nol, fn, fn_nol;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  chan_fault_reg #(.NUM_CH(8), .OL_DET_EN(1'b1)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .oc_det_i(oc_det_i), .ol_det_i(ol_det_i),
    .data_i(data_i), .ot_i(ot_i), .uv_i(uv_i), .flt_clr_i(flt_clr_i),
    .fault_word_o(word), .force_off_o(foff), .out_dis_o(dis), .fault_no(fn));

  chan_fault_reg #(.NUM_CH(8), .OL_DET_EN(1'b0)) dut_nol (
    .clk_i(clk_i), .rst_ni(rst_ni), .oc_det_i(oc_det_i), .ol_det_i(ol_det_i),
    .data_i(data_i), .ot_i(ot_i), .uv_i(uv_i), .flt_clr_i(flt_clr_i),
    .fault_word_o(word_nol), .force_off_o(foff_nol), .out_dis_o(dis_nol),
    .fault_no(fn_nol));

  // oc, ol, data, ot, uv, clr | expected word, fault_no, out_dis
  localparam int NV = 18;
  localparam logic [44:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 3'b000, 16'h0000, 2'b10}, // R1 idle
    {8'h01, 8'h00, 8'h01, 3'b000, 16'h0100, 2'b00}, // R3 oc ch0
    {8'h00, 8'h00, 8'h01, 3'b000, 16'h0100, 2'b00}, // R3 sticky
    {8'h00, 8'h00, 8'h00, 3'b000, 16'h0000, 2'b10}, // R4 data fall clears
    {8'h00, 8'h04, 8'h00, 3'b000, 16'h0004, 2'b00}, // R5 ol ch2
    {8'h00, 8'h08, 8'h08, 3'b000, 16'h0004, 2'b00}, // R5 ol ignored, data on
    {8'h00, 8'h00, 8'h0C, 3'b000, 16'h0000, 2'b10}, // R6 data rise clears
    {8'h80, 8'h01, 8'h0C, 3'b000, 16'h8001, 2'b00}, // R2 bit positions
    {8'h04, 8'h00, 8'h0C, 3'b001, 16'h0000, 2'b10}, // R7 reset beats detect
    {8'h00, 8'h00, 8'h0C, 3'b100, 16'h0000, 2'b01}, // R9 over-temp
    {8'h00, 8'h00, 8'h0C, 3'b000, 16'h0000, 2'b10}, // R9 release
    {8'h04, 8'h00, 8'h0C, 3'b000, 16'h0400, 2'b00}, // R8 oc ch2
    {8'h00, 8'h00, 8'h0C, 3'b010, 16'h0000, 2'b11}, // R10 uv wipe
    {8'hFF, 8'h00, 8'hFF, 3'b010, 16'h0000, 2'b11}, // R10 detects ignored
    {8'h00, 8'h00, 8'h00, 3'b000, 16'h0000, 2'b10}, // R10 recover
    {8'h10, 8'h10, 8'h00, 3'b000, 16'h1010, 2'b00}, // R2 both flags ch4
    {8'h10, 8'h00, 8'h10, 3'b000, 16'h1000, 2'b00}, // R6 ol clears, oc stays
    {8'h10, 8'h00, 8'h00, 3'b000, 16'h1000, 2'b00}  // R4 detect beats fall
  };

  function automatic string req_of(int idx);
    case (idx)
      0: return "R1";
      1, 2: return "R3";
      3, 17: return "R4";
      4, 5: return "R5";
      6, 16: return "R6";
      7, 15: return "R2";
      8: return "R7";
      9, 10: return "R9";
      11: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #35;
    chk("R1", word, 16'h0);
    chk("R1", foff, 8'h0);
    chk("R1", fn, 1'b1);
    chk("R1", dis, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      {oc_det_i, ol_det_i, data_i, ot_i, uv_i, flt_clr_i} = VEC[k][44:18];
      @(posedge clk_i);
      #2;
      chk(req_of(k), word, VEC[k][17:2]);
      chk(req_of(k), fn, VEC[k][1]);
      chk(req_of(k), dis, VEC[k][0]);
      chk("R3", foff, VEC[k][17:10]);
      chk("R11", word_nol, {VEC[k][17:10], 8'h00});
    end

    // R9: flags survive over-temperature
    @(negedge clk_i);
    oc_det_i = '0; ol_det_i = '0; ot_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R9", word, 16'h1000);
    chk("R9", dis, 1'b1);
    @(negedge clk_i) ot_i = 1'b0;
    #2;
    chk("R9", dis, 1'b0);
    chk("R8", fn, 1'b0);
    chk("R3", foff, 8'h10);

    // R1: asynchronous reset mid-cycle
    #3 rst_ni = 1'b0;
    #1;
    chk("R1", word, 16'h0);
    chk("R1", foff, 8'h0);
    chk("R1", fn, 1'b1);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule